// File: doc/BRIEF.md
# Translation Fault Status Capture

This block holds the status and address of the most recent translation fault reported by a page table walker. The walker raises a one-cycle fault strobe. With it, the walker gives the fault level, the fault type, a 3-bit access index (kind of access and privilege), the faulting virtual address, and two qualifiers: whether the access came from user mode and whether the fault is a permission fault. The CPU reads the status register through a read strobe. A read returns the current value and empties the register. If a second fault arrives before the first has been read, the register keeps only an overflow mark plus the newest fields.

In the same cycle as each strobe, the block tells the requester one of two things. It either raises a trap request, or it signals a no-fault override, which means the access proceeds with read, write and execute permission. The override is chosen while the no-fault control input is set or while traps are disabled. User-mode permission faults are dropped entirely while no-fault mode is on.

The status register is driven by a three-state machine:
- ST_EMPTY: nothing recorded, status is zero.
- ST_HELD: one unread fault.
- ST_OVFL: at least two faults arrived without a read in between.

Transitions:
- EMPTY→HELD on an accepted fault.
- HELD→OVFL and OVFL→OVFL on an accepted fault without a read.
- HELD→EMPTY and OVFL→EMPTY on a read without a fault.
- HELD→HELD and OVFL→HELD on a read that coincides with an accepted fault.

Top module: `mfc_capture`

## Requirements
- R1: After reset, status and fault_addr are zero, and trap_req and override_rwx are low.
- R2: An accepted fault into an empty register loads status = (access<<5) | (level<<8) | (type<<2) | 2 one clock later. Bit 1 marks the address as valid, and bit 0 is the overflow mark. Status is 10 bits wide.
- R3: An accepted fault that arrives while status is nonzero, without a read in the same cycle, loads 1 | the new fields. The earlier fields are discarded.
- R4: A cycle with status_rd high and no accepted fault makes status zero one clock later. status shows the old value during the read cycle.
- R5: When status_rd and an accepted fault coincide, status becomes the new fields with bit 0 clear.
- R6: Every accepted fault loads fault_addr with flt_vaddr one clock later, overflow included. With no accepted fault, fault_addr holds its value.
- R7: During an accepted fault with traps_en high and nofault_en low, trap_req is high in the same cycle and override_rwx is low.
- R8: During an accepted fault with nofault_en high or traps_en low, override_rwx is high in the same cycle and trap_req is low. The status is still recorded.
- R9: A fault with flt_user, flt_perm and nofault_en all high is not accepted. status (unless read) and fault_addr are unchanged, and trap_req and override_rwx stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flt_valid | input | 1 | Fault strobe from the walker |
| flt_level | input | 2 | Table level where the fault occurred |
| flt_type | input | 3 | Fault type code |
| flt_access | input | 3 | Access index of the faulting access |
| flt_vaddr | input | VA_W | Faulting virtual address |
| flt_user | input | 1 | Access was made in user mode |
| flt_perm | input | 1 | Fault is a permission fault |
| nofault_en | input | 1 | No-fault mode control |
| traps_en | input | 1 | Traps enabled in the CPU |
| status_rd | input | 1 | CPU read of the status register |
| status | output | 10 | Fault status register |
| fault_addr | output | VA_W | Fault address register |
| trap_req | output | 1 | Raise a trap for this fault |
| override_rwx | output | 1 | Proceed with full permissions instead of trapping |

## Verification
The hardest case to reach from the ports is a read that lands in the same cycle as a fresh fault while the register is already in overflow. Both OVFL→HELD and the bit-0-clear result depend on that exact alignment. The bench drives it deliberately: two back-to-back faults, then a third fault together with the read strobe. It then issues a long run of random strobes, reads and mode bits so that suppressed faults also land between unread ones. A behavioural reference model is compared against the outputs on every cycle.

// File: rtl/mfc_pkg.sv
package mfc_pkg;
    localparam int LVL_W   = 2;
    localparam int TYPE_W  = 3;
    localparam int ACC_W   = 3;
    localparam int TYPE_LSB = 2;
    localparam int ACC_LSB  = 5;
    localparam int LVL_LSB  = 8;
    localparam int STAT_W   = LVL_LSB + LVL_W;
    localparam int OVF_BIT  = 0;
    localparam int AVAL_BIT = 1;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_HELD  = 2'd1,
        ST_OVFL  = 2'd2
    } cap_state_e;
endpackage

// File: rtl/mfc_policy.sv
module mfc_policy (
    input  logic flt_valid,
    input  logic flt_user,
    input  logic flt_perm,
    input  logic nofault_en,
    input  logic traps_en,
    output logic accept,
    output logic trap_req,
    output logic override_rwx
);
    logic suppress;
    logic quiet;

    always_comb begin
        suppress     = flt_user && flt_perm && nofault_en;
        accept       = flt_valid && !suppress;
        quiet        = nofault_en || !traps_en;
        trap_req     = accept && !quiet;
        override_rwx = accept && quiet;
    end

    always_comb begin
        a_r7_r8_exclusive: assert (!(trap_req && override_rwx));
    end
endmodule

// File: rtl/mfc_status_fsm.sv
module mfc_status_fsm
    import mfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              rd,
    input  logic [ACC_W-1:0]  acc,
    input  logic [LVL_W-1:0]  lvl,
    input  logic [TYPE_W-1:0] typ,
    output logic [STAT_W-1:0] status
);
    cap_state_e        state_q, state_d;
    logic [STAT_W-1:0] status_q, status_d;
    logic [STAT_W-1:0] fields;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_EMPTY;
            status_q <= '0;
        end else begin
            state_q  <= state_d;
            status_q <= status_d;
        end
    end

    always_comb begin
        fields = '0;
        fields[ACC_LSB +: ACC_W]   = acc;
        fields[LVL_LSB +: LVL_W]   = lvl;
        fields[TYPE_LSB +: TYPE_W] = typ;
        fields[AVAL_BIT]           = 1'b1;
        state_d  = state_q;
        status_d = status_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (accept) begin
                    state_d  = ST_HELD;
                    status_d = fields;
                end
            end
            ST_HELD, ST_OVFL: begin
                if (accept && rd) begin
                    state_d  = ST_HELD;
                    status_d = fields;
                end else if (accept) begin
                    state_d  = ST_OVFL;
                    status_d = fields;
                    status_d[OVF_BIT] = 1'b1;
                end else if (rd) begin
                    state_d  = ST_EMPTY;
                    status_d = '0;
                end
            end
            default: begin
                state_d  = ST_EMPTY;
                status_d = '0;
            end
        endcase
    end

    assign status = status_q;

    a_r2_valid_bit: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> status_q[AVAL_BIT]);
    a_r3_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !rd && status_q != '0) |=> status_q[OVF_BIT]);
    a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !accept) |=> (status_q == '0));
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && accept) |=> !status_q[OVF_BIT]);
    a_r1_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMPTY) |-> (status_q == '0));
endmodule

// File: rtl/mfc_addr_reg.sv
module mfc_addr_reg #(
    parameter int VA_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [VA_W-1:0] vaddr,
    output logic [VA_W-1:0] addr
);
    always_ff @(posedge clk) begin
        if (!rst_n)    addr <= '0;
        else if (load) addr <= vaddr;
    end

    a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (addr == $past(vaddr)));
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(addr));
endmodule

// File: rtl/mfc_capture.sv
module mfc_capture
    import mfc_pkg::*;
#(
    parameter int VA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flt_valid,
    input  logic [LVL_W-1:0]  flt_level,
    input  logic [TYPE_W-1:0] flt_type,
    input  logic [ACC_W-1:0]  flt_access,
    input  logic [VA_W-1:0]   flt_vaddr,
    input  logic              flt_user,
    input  logic              flt_perm,
    input  logic              nofault_en,
    input  logic              traps_en,
    input  logic              status_rd,
    output logic [STAT_W-1:0] status,
    output logic [VA_W-1:0]   fault_addr,
    output logic              trap_req,
    output logic              override_rwx
);
    logic accept;

    mfc_policy u_policy (
        .flt_valid   (flt_valid),
        .flt_user    (flt_user),
        .flt_perm    (flt_perm),
        .nofault_en  (nofault_en),
        .traps_en    (traps_en),
        .accept      (accept),
        .trap_req    (trap_req),
        .override_rwx(override_rwx)
    );

    mfc_status_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .accept(accept),
        .rd    (status_rd),
        .acc   (flt_access),
        .lvl   (flt_level),
        .typ   (flt_type),
        .status(status)
    );

    mfc_addr_reg #(.VA_W(VA_W)) u_addr (
        .clk  (clk),
        .rst_n(rst_n),
        .load (accept),
        .vaddr(flt_vaddr),
        .addr (fault_addr)
    );

    a_r9_suppressed: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && flt_user && flt_perm && nofault_en && !status_rd)
        |=> ($stable(status) && $stable(fault_addr)));
endmodule

// File: tb/mfc_capture_test.sv
module mfc_capture_test;
    localparam int VA_W = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            flt_valid = 0, flt_user = 0, flt_perm = 0;
    logic            nofault_en = 0, traps_en = 1, status_rd = 0;
    logic [1:0]      flt_level = 0;
    logic [2:0]      flt_type = 0, flt_access = 0;
    logic [VA_W-1:0] flt_vaddr = 0;
    logic [9:0]      status;
    logic [VA_W-1:0] fault_addr;
    logic            trap_req, override_rwx;

    int n_chk = 0, n_fail = 0;
    int m_stat = 0;
    longint m_addr = 0;

    always #5 clk = ~clk;

    mfc_capture #(.VA_W(VA_W)) uut (
        .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_level(flt_level),
        .flt_type(flt_type), .flt_access(flt_access), .flt_vaddr(flt_vaddr),
        .flt_user(flt_user), .flt_perm(flt_perm), .nofault_en(nofault_en),
        .traps_en(traps_en), .status_rd(status_rd), .status(status),
        .fault_addr(fault_addr), .trap_req(trap_req), .override_rwx(override_rwx)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // one cycle: drive at negedge, check same-cycle outputs, clock, check registers
    task automatic step(input string tag, input bit v, input int lvl, input int typ,
                        input int acc, input longint va, input bit usr, input bit perm,
                        input bit nf, input bit te, input bit rd);
        bit acc_ok, quiet;
        int fields;
        @(negedge clk);
        flt_valid = v; flt_level = 2'(lvl); flt_type = 3'(typ); flt_access = 3'(acc);
        flt_vaddr = VA_W'(va); flt_user = usr; flt_perm = perm;
        nofault_en = nf; traps_en = te; status_rd = rd;
        #1;
        acc_ok = v && !(usr && perm && nf);
        quiet  = nf || !te;
        chk({tag, " R7 trap_req"}, longint'(trap_req), longint'(acc_ok && !quiet));
        chk({tag, " R8 override_rwx"}, longint'(override_rwx), longint'(acc_ok && quiet));
        fields = acc * 32 + lvl * 256 + typ * 4 + 2;
        if (acc_ok) begin
            m_stat = (rd || m_stat == 0) ? fields : (fields | 1);
            m_addr = va;
        end else if (rd) begin
            m_stat = 0;
        end
        @(posedge clk); #1;
        chk({tag, " status"}, longint'(status), longint'(m_stat));
        chk({tag, " R6 fault_addr"}, longint'(fault_addr), m_addr);
    endtask

    task automatic idle(input string tag);
        step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    endtask

    initial begin
        #200000;
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 status reset", longint'(status), 0);
        chk("R1 addr reset", longint'(fault_addr), 0);
        chk("R1 trap reset", longint'(trap_req), 0);
        chk("R1 override reset", longint'(override_rwx), 0);
        @(negedge clk); rst_n = 1'b1;
        idle("R1 idle");
        // R2 first fault, R7 trap
        step("R2 first", 1, 2, 1, 5, 64'h1234_5000, 0, 0, 0, 1, 0);
        chk("R2 exact", longint'(status), longint'(10'h2A6));
        // R3 overflow
        step("R3 second", 1, 1, 4, 3, 64'hDEAD_B000, 1, 0, 0, 1, 0);
        chk("R3 exact", longint'(status), longint'(10'h173));
        step("R3 third", 1, 3, 2, 7, 64'hCAFE_0000, 0, 1, 0, 1, 0);
        // R5 read with fault while overflowed
        step("R5 coincide", 1, 0, 6, 2, 64'h0000_F000, 0, 0, 0, 1, 1);
        chk("R5 no ovf bit", longint'(status[0]), 0);
        // R4 read clears
        step("R4 read", 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
        chk("R4 zero", longint'(status), 0);
        // R8 no-fault mode and traps disabled
        step("R8 nofault", 1, 1, 1, 1, 64'h4444_4000, 0, 1, 1, 1, 0);
        step("R8 traps off", 1, 2, 3, 4, 64'h5555_5000, 1, 1, 0, 0, 0);
        // R9 suppressed user permission fault
        step("R9 suppressed", 1, 3, 3, 6, 64'h9999_9000, 1, 1, 1, 1, 0);
        step("R9 suppressed+rd", 1, 3, 3, 6, 64'h7777_7000, 1, 1, 1, 0, 1);
        idle("R6 hold");
        for (int i = 0; i < 400; i++) begin
            step("rand R2 R3 R4 R5 R9", ($urandom % 3) != 0, int'($urandom % 4),
                 int'($urandom % 8), int'($urandom % 8), longint'($urandom),
                 1'($urandom), 1'($urandom), ($urandom % 4) == 0,
                 ($urandom % 4) != 0, ($urandom % 3) == 0);
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule